// File: doc/BRIEF.md
# Banked GPIO Controller with Edge and Level Interrupts

This block gives software control over a set of general-purpose pins arranged as several equal banks. A simple 32-bit register bus reaches it: a select, a write flag, a byte address and write data, with read data returned in the same cycle. Each pin has a direction bit that drives its tri-state output enable and an output latch. Software changes the latch through separate set and clear strobe registers, so no read-modify-write cycle is needed. An input inversion mask sits in front of all input logic.

Inputs pass through a multi-flop synchronizer. The synchronized and inverted level can be read back. Per-pin masks arm interrupts on rising edges, falling edges, high levels and low levels. Any armed event sets a sticky pending bit, which software clears by writing a one to it. A side register records whether a rising or a falling edge last set each pending bit. One registered interrupt line is high while any pending bit in any bank is set.

Top module: `gpio_multibank`

## Requirements
- R1: Registers sit at byte address kind*16 + bank*4. The kinds, in index order, are: 0 direction, 1 inversion, 2 level, 3 set-strobe, 4 clear-strobe, 5 rise-enable, 6 fall-enable, 7 high-enable, 8 low-enable, 9 pending, 10 edge-kind. Read data appears in the same cycle as a read access, i.e. when bus_sel=1 and bus_we=0.
- R2: After reset, every register reads zero and pin_oe, pin_out and irq are all zero.
- R3: A direction bit of 1 makes the pin an output and drives its pin_oe bit high; 0 makes it an input. The register reads back what was written, and pin_oe changes only on a write.
- R4: Writing the set-strobe register sets the latch bits where the data has ones. Writing the clear-strobe register clears those bits. Zero bits leave the latch unchanged. pin_out shows the latch, and reading either strobe slot returns the latch.
- R5: The level register returns the synchronized pin value XOR the inversion mask. An input change becomes visible after the second rising clock edge.
- R6: An inversion bit of 1 inverts that pin's level for readback and for all interrupt detection. All zeros means no inversion.
- R7: A pending bit sets on the third rising edge after its input changes, provided the matching rise-enable or fall-enable bit is set. An edge in a direction that is not enabled sets nothing.
- R8: Pending bits are sticky. Writing a 1 clears only that bit; bits written with 0 are kept.
- R9: While a pin's level matches a set high-enable or low-enable bit, its pending bit is set on every cycle, so clearing it has no effect until the level goes away or the enable is cleared.
- R10: When a new event and a write-one-to-clear hit the same pending bit in the same cycle, the bit stays set.
- R11: The edge-kind register is read-only. A bit reads 1 if a rising edge last set that pending bit and 0 if a falling edge did. Level events leave it unchanged.
- R12: irq is registered. It is high exactly while any pending bit in any bank is set, and it changes on the same clock edge as the pending bits.
- R13: An access is unmapped if its kind index is above 10, its bank field (address bits 3:2) is at least NUM_BANKS, or its address bits 1:0 are nonzero. An unmapped access reads zero and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | BANK_W | Write data |
| bus_rdata | output | BANK_W | Read data, same cycle |
| pin_in | input | NUM_BANKS*BANK_W | Asynchronous pad inputs, pin = bank*BANK_W + bit |
| pin_out | output | NUM_BANKS*BANK_W | Output latch values |
| pin_oe | output | NUM_BANKS*BANK_W | Tri-state output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: three banks of 32 pins, an 8-bit address and a two-stage synchronizer. Because there are three banks, bank field value 3 is a real hole in the map, so the bench can check that an access there reads zero and cannot move any pin. The full 32-bit bank width also lets pins in bank 1 and bank 2 be driven at nonzero bit offsets, which checks that the pin index is bank*32 + bit in both the direction and the interrupt paths.

// File: rtl/gpio_mb_pkg.sv
package gpio_mb_pkg;

    // Number of register kinds and address field positions
    localparam int unsigned KIND_COUNT = 11;
    localparam int unsigned SLOT_LSB   = 4;   // 16-byte slot per register kind
    localparam int unsigned BANK_LSB   = 2;   // 4-byte step per bank

    typedef enum logic [3:0] {
        RK_DIR     = 4'd0,
        RK_INV     = 4'd1,
        RK_LEVEL   = 4'd2,
        RK_SETOUT  = 4'd3,
        RK_CLROUT  = 4'd4,
        RK_RISE_EN = 4'd5,
        RK_FALL_EN = 4'd6,
        RK_HIGH_EN = 4'd7,
        RK_LOW_EN  = 4'd8,
        RK_PEND    = 4'd9,
        RK_KIND    = 4'd10
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        logic [1:0] bank;
        reg_kind_e kind;
    } dec_t;

endpackage

// File: rtl/gpio_mb_sync.sv
module gpio_mb_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mb_decode.sv
module gpio_mb_decode
    import gpio_mb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_BANKS = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int unsigned KIND_W = ADDR_W - SLOT_LSB;

    logic [KIND_W-1:0] kind_raw;
    logic [1:0]        bank_raw;
    logic              aligned;

    always_comb begin
        kind_raw = addr[ADDR_W-1:SLOT_LSB];
        bank_raw = addr[SLOT_LSB-1:BANK_LSB];
        aligned  = (addr[BANK_LSB-1:0] == '0);
        dec.hit  = aligned
                 && (32'(kind_raw) < KIND_COUNT)
                 && (32'(bank_raw) < NUM_BANKS);
        dec.bank = bank_raw;
        dec.kind = reg_kind_e'(kind_raw[3:0]);
    end
endmodule

// File: rtl/gpio_mb_bank.sv
module gpio_mb_bank
    import gpio_mb_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pend,
    output logic         pend_nxt_any
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] inv;
        logic [W-1:0] latch;
        logic [W-1:0] rise_en;
        logic [W-1:0] fall_en;
        logic [W-1:0] high_en;
        logic [W-1:0] low_en;
        logic [W-1:0] pend;
        logic [W-1:0] kind;
        logic [W-1:0] prev;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [W-1:0] lvl;
    logic [W-1:0] rise_ev;
    logic [W-1:0] fall_ev;
    logic [W-1:0] lvl_ev;
    logic [W-1:0] clr_mask;

    always_comb begin
        lvl      = pin_sync ^ st_q.inv;
        rise_ev  = lvl & ~st_q.prev & st_q.rise_en;
        fall_ev  = ~lvl & st_q.prev & st_q.fall_en;
        lvl_ev   = (lvl & st_q.high_en) | (~lvl & st_q.low_en);
        clr_mask = (wr_en && kind == RK_PEND) ? wr_data : '0;

        st_d      = st_q;
        st_d.prev = lvl;
        if (wr_en) begin
            case (kind)
                RK_DIR:     st_d.dir     = wr_data;
                RK_INV:     st_d.inv     = wr_data;
                RK_SETOUT:  st_d.latch   = st_q.latch | wr_data;
                RK_CLROUT:  st_d.latch   = st_q.latch & ~wr_data;
                RK_RISE_EN: st_d.rise_en = wr_data;
                RK_FALL_EN: st_d.fall_en = wr_data;
                RK_HIGH_EN: st_d.high_en = wr_data;
                RK_LOW_EN:  st_d.low_en  = wr_data;
                default:    ;
            endcase
        end
        // new events take priority over a same-cycle clear
        st_d.pend = (st_q.pend & ~clr_mask) | rise_ev | fall_ev | lvl_ev;
        st_d.kind = (st_q.kind | rise_ev) & ~fall_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (kind)
            RK_DIR:     rd_data = st_q.dir;
            RK_INV:     rd_data = st_q.inv;
            RK_LEVEL:   rd_data = lvl;
            RK_SETOUT:  rd_data = st_q.latch;
            RK_CLROUT:  rd_data = st_q.latch;
            RK_RISE_EN: rd_data = st_q.rise_en;
            RK_FALL_EN: rd_data = st_q.fall_en;
            RK_HIGH_EN: rd_data = st_q.high_en;
            RK_LOW_EN:  rd_data = st_q.low_en;
            RK_PEND:    rd_data = st_q.pend;
            RK_KIND:    rd_data = st_q.kind;
            default:    rd_data = '0;
        endcase
    end

    assign pin_out      = st_q.latch;
    assign pin_oe       = st_q.dir;
    assign pend         = st_q.pend;
    assign pend_nxt_any = |st_d.pend;
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_mb_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = 3,
    parameter int unsigned BANK_W      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_sel,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [BANK_W-1:0]             bus_wdata,
    output logic [BANK_W-1:0]             bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0]   pin_in,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_out,
    output logic [NUM_BANKS*BANK_W-1:0]   pin_oe,
    output logic                          irq
);
    localparam int unsigned PIN_W = NUM_BANKS * BANK_W;

    typedef struct packed {
        logic irq;
    } top_st_t;

    top_st_t top_d, top_q;

    dec_t               dec;
    logic [PIN_W-1:0]   pin_sync;
    logic [PIN_W-1:0]   stat_flat;
    logic [BANK_W-1:0]  bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_nxt_any;

    gpio_mb_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    gpio_mb_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_sel && bus_we && dec.hit && (32'(dec.bank) == b);

        gpio_mb_bank #(.W(BANK_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (bank_wr),
            .kind        (dec.kind),
            .wr_data     (bus_wdata),
            .pin_sync    (pin_sync[b*BANK_W +: BANK_W]),
            .rd_data     (bank_rd[b]),
            .pin_out     (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe      (pin_oe[b*BANK_W +: BANK_W]),
            .pend        (stat_flat[b*BANK_W +: BANK_W]),
            .pend_nxt_any(bank_nxt_any[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && dec.hit) begin
            for (int b = 0; b < int'(NUM_BANKS); b++) begin
                if (32'(dec.bank) == b) begin
                    bus_rdata = bank_rd[b];
                end
            end
        end
    end

    always_comb begin
        top_d     = top_q;
        top_d.irq = |bank_nxt_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq = top_q.irq;
endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk #(
    parameter int unsigned NUM_BANKS = 3,
    parameter int unsigned BANK_W    = 32,
    parameter int unsigned ADDR_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_sel,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [BANK_W-1:0]           bus_rdata,
    input logic [NUM_BANKS*BANK_W-1:0] pin_out,
    input logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    input logic [NUM_BANKS*BANK_W-1:0] stat_flat,
    input logic                        irq
);
    logic unmapped;
    always_comb begin
        unmapped = (32'(bus_addr[ADDR_W-1:4]) > 32'd10)
                || (bus_addr[1:0] != 2'b00)
                || (32'(bus_addr[3:2]) >= NUM_BANKS);
    end

    AST_IRQ_TRACKS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|stat_flat)); // R12

    AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> $stable(pin_oe)); // R3

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> $stable(pin_out)); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> ((stat_flat & $past(stat_flat)) == $past(stat_flat))); // R8

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && unmapped) |-> (bus_rdata == '0)); // R13

    AST_UNMAPPED_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && unmapped) |=> ($stable(pin_oe) && $stable(pin_out))); // R13
endmodule

bind gpio_multibank gpio_multibank_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .stat_flat(stat_flat),
    .irq      (irq)
);

// File: tb/tb_gpio_multibank.sv
module tb_gpio_multibank;
    localparam int NB = 3;
    localparam int W  = 32;
    localparam int AW = 8;
    localparam int PW = NB * W;

    localparam int K_DIR = 0, K_INV = 1, K_LEVEL = 2, K_SET = 3, K_CLR = 4;
    localparam int K_RISE = 5, K_FALL = 6, K_HIGH = 7, K_LOW = 8, K_PEND = 9, K_KIND = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out;
    logic [PW-1:0] pin_oe;
    logic          irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_multibank #(.NUM_BANKS(NB), .BANK_W(W), .ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [AW-1:0] ra(int kind, int bank);
        return AW'(kind * 16 + bank * 4);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [W-1:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(ra(K_DIR, 0), v);   check("R2 dir reset", v, '0);
        rd(ra(K_PEND, 2), v);  check("R2 pend reset", v, '0);
        check("R2 irq reset", {31'b0, irq}, 32'd0);
        check("R2 oe reset", {31'b0, |pin_oe}, 32'd0);
        check("R2 out reset", {31'b0, |pin_out}, 32'd0);
    endtask

    task automatic t_dir();
        logic [W-1:0] v;
        wr(ra(K_DIR, 1), 32'hA5A5_0F0F);
        check("R3 oe bank1", pin_oe[63:32], 32'hA5A5_0F0F);
        check("R3 oe bank0 untouched", pin_oe[31:0], 32'h0);
        rd(ra(K_DIR, 1), v); check("R1 dir readback", v, 32'hA5A5_0F0F);
    endtask

    task automatic t_setclr();
        logic [W-1:0] v;
        wr(ra(K_SET, 2), 32'h0000_00F0);
        wr(ra(K_SET, 2), 32'h0F00_0000);
        check("R4 set accumulates", pin_out[95:64], 32'h0F00_00F0);
        wr(ra(K_CLR, 2), 32'h0000_00C0);
        check("R4 clear selective", pin_out[95:64], 32'h0F00_0030);
        rd(ra(K_CLR, 2), v); check("R4 latch readback", v, 32'h0F00_0030);
    endtask

    task automatic t_level();
        logic [W-1:0] v;
        pin_in[31:0] = 32'h1234_5678;
        wait_cyc(1);
        rd(ra(K_LEVEL, 0), v); check("R5 not yet visible", v, 32'h0);
        wait_cyc(1);
        rd(ra(K_LEVEL, 0), v); check("R5 level visible", v, 32'h1234_5678);
    endtask

    task automatic t_pol();
        logic [W-1:0] v;
        wr(ra(K_INV, 0), 32'hFFFF_0000);
        rd(ra(K_LEVEL, 0), v); check("R6 inverted level", v, 32'hEDCB_5678);
        wr(ra(K_INV, 0), 32'h0);
        rd(ra(K_LEVEL, 0), v); check("R6 zero means plain", v, 32'h1234_5678);
    endtask

    task automatic t_edge();
        logic [W-1:0] v;
        wr(ra(K_RISE, 1), 32'h8);
        pin_in[35] = 1'b1;
        wait_cyc(2);
        check("R7 not yet pending", {31'b0, irq}, 32'd0);
        wait_cyc(1);
        check("R7 irq on rise", {31'b0, irq}, 32'd1);
        rd(ra(K_PEND, 1), v); check("R7 pend rise", v, 32'h8);
        rd(ra(K_KIND, 1), v); check("R11 rising kind", v, 32'h8);
        wr(ra(K_PEND, 1), 32'h8);
        check("R12 irq drops", {31'b0, irq}, 32'd0);
        pin_in[35] = 1'b0;
        wait_cyc(4);
        rd(ra(K_PEND, 1), v); check("R7 disabled fall ignored", v, 32'h0);
        pin_in[35] = 1'b1;
        wait_cyc(3);
        rd(ra(K_PEND, 1), v); check("R7 pend rise again", v, 32'h8);
        wr(ra(K_FALL, 1), 32'h8);
        pin_in[35] = 1'b0;
        wait_cyc(2);
        wr(ra(K_PEND, 1), 32'h8);   // lands on the falling event cycle
        rd(ra(K_PEND, 1), v); check("R10 event beats clear", v, 32'h8);
        rd(ra(K_KIND, 1), v); check("R11 falling kind", v, 32'h0);
        wr(ra(K_PEND, 1), 32'h8);
        rd(ra(K_PEND, 1), v); check("R8 cleared", v, 32'h0);
        wr(ra(K_RISE, 1), 32'h0);
        wr(ra(K_FALL, 1), 32'h0);
    endtask

    task automatic t_w1c();
        logic [W-1:0] v;
        wr(ra(K_RISE, 2), 32'h3);
        pin_in[65:64] = 2'b11;
        wait_cyc(3);
        rd(ra(K_PEND, 2), v); check("R7 two pins bank2", v, 32'h3);
        wr(ra(K_PEND, 2), 32'h1);
        rd(ra(K_PEND, 2), v); check("R8 only written bit clears", v, 32'h2);
        wr(ra(K_KIND, 2), 32'hFFFF_FFFF);
        rd(ra(K_KIND, 2), v); check("R11 kind read-only", v, 32'h3);
        check("R12 irq held", {31'b0, irq}, 32'd1);
        wr(ra(K_PEND, 2), 32'h2);
        check("R12 irq clear", {31'b0, irq}, 32'd0);
        wr(ra(K_RISE, 2), 32'h0);
    endtask

    task automatic t_levelint();
        logic [W-1:0] v;
        wr(ra(K_HIGH, 0), 32'h10);
        wait_cyc(1);
        rd(ra(K_PEND, 0), v); check("R9 high level pend", v, 32'h10);
        wr(ra(K_PEND, 0), 32'h10);
        rd(ra(K_PEND, 0), v); check("R9 clear while high", v, 32'h10);
        wr(ra(K_HIGH, 0), 32'h0);
        wr(ra(K_PEND, 0), 32'h10);
        rd(ra(K_PEND, 0), v); check("R9 cleared after disable", v, 32'h0);
        wr(ra(K_LOW, 0), 32'h1);
        wait_cyc(1);
        rd(ra(K_PEND, 0), v); check("R9 low level pend", v, 32'h1);
        rd(ra(K_KIND, 0), v); check("R11 level leaves kind", v, 32'h0);
        wr(ra(K_LOW, 0), 32'h0);
        wr(ra(K_PEND, 0), 32'h1);
        rd(ra(K_PEND, 0), v); check("R8 low cleared", v, 32'h0);
    endtask

    task automatic t_irq_multi();
        logic [W-1:0] v;
        wr(ra(K_HIGH, 0), 32'h10);
        wr(ra(K_HIGH, 2), 32'h1);
        wait_cyc(1);
        check("R12 irq two banks", {31'b0, irq}, 32'd1);
        wr(ra(K_HIGH, 0), 32'h0);
        wr(ra(K_PEND, 0), 32'h10);
        rd(ra(K_PEND, 0), v); check("R12 bank0 cleared", v, 32'h0);
        check("R12 irq from bank2", {31'b0, irq}, 32'd1);
        wr(ra(K_HIGH, 2), 32'h0);
        wr(ra(K_PEND, 2), 32'h1);
        check("R12 irq all clear", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [W-1:0] v;
        logic [PW-1:0] oe_before;
        logic [PW-1:0] out_before;
        oe_before  = pin_oe;
        out_before = pin_out;
        wr(8'hB0, 32'hFFFF_FFFF);
        rd(8'hB0, v); check("R13 kind 11 reads zero", v, 32'h0);
        wr(ra(K_DIR, 3), 32'hFFFF_FFFF);
        wr(ra(K_SET, 3), 32'hFFFF_FFFF);
        check("R13 bank3 oe unchanged", {31'b0, pin_oe == oe_before}, 32'd1);
        check("R13 bank3 out unchanged", {31'b0, pin_out == out_before}, 32'd1);
        rd(ra(K_DIR, 3), v); check("R13 bank3 reads zero", v, 32'h0);
        wr(ra(K_DIR, 0) + 8'd1, 32'hFFFF_FFFF);
        rd(ra(K_DIR, 0), v); check("R13 misaligned write ignored", v, 32'h0);
        rd(ra(K_DIR, 1) + 8'd2, v); check("R13 misaligned read zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_setclr();
        t_level();
        t_pol();
        t_edge();
        t_w1c();
        t_levelint();
        t_irq_multi();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule